// File: doc/BRIEF.md
# Fixed-Point Biquad Filter Engine

This block computes one or two cascaded second-order IIR sections in direct form I, using 16-bit signed fractional samples with two integer bits and fourteen fraction bits (one is 0x4000). A sample enters through a valid/ready handshake. A single shared multiplier then works through a fixed schedule of multiply-accumulate steps, one step per clock. The result leaves as a one-cycle output pulse.

Coefficients and filter history sit in two small internal register files. Two counters walk them: a coefficient index that moves forward after every coefficient read, and a history index that steps up and down. When two sections are selected, the second section picks up the history index where the first one stopped. The first section's output history therefore doubles as the second section's input history, so six history words serve both sections. Software loads coefficients through a plain write port before it streams samples.

Top module: `biquad_engine`

## Requirements
- R1: Every product is the full signed 32-bit product of a coefficient and an operand, shifted arithmetically right by 14. This rounds toward negative infinity, so coefficient 0x2000 times sample 0xFFFF gives 0xFFFF, and 0x2000 times 0x0003 gives 0x0001.
- R2: Section k reads its coefficients from addresses 5k to 5k+4, in this order: feed-forward for the present input, feed-forward for the delayed inputs one and two, then feedback for the delayed outputs one and two. Feedback products are added, so feedback coefficients are stored with their sign already applied.
- R3: Products are summed in a 32-bit accumulator. The section result is the low 16 bits of that sum, with no saturation, so 0x7FFF + 0x7FFF yields 0xFFFE.
- R4: After its feed-forward taps, a section shifts its input into its input-history pair: the newest word takes the input and the older word takes the previous newest. One sample later, an input reappears through the delay-one tap, and two samples later through the delay-two tap.
- R5: With two sections, the history words form one chain of six: input history of section one, then output history of section one (which is also input history of section two), then output history of section two.
- R6: `twoSection` is sampled when a sample is accepted. When it is 0, only section one runs and its output is shifted into history words 2 and 3. Section-two coefficients then have no effect on the output.
- R7: `inReady` is high only while idle. A sample is taken on a rising edge with `inValid` and `inReady` both high, and `inReady` stays low until the result has been emitted.
- R8: `outValid` is a single-cycle pulse. It is sampled high on the 8th rising edge after the accepting edge with one section, and on the 14th with two. `outData` holds the result until the next sample is accepted.
- R9: When `coefWe` is high at an edge, `coefData` is written to coefficient address `coefAddr`. Addresses 0 to 9 are valid; writes to 10 to 15 are ignored.
- R10: Synchronous active-high `rst` clears all history words, all coefficients and `outData`. It leaves `inReady` high and `outValid` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Input sample offered |
| inReady | output | 1 | Engine idle and able to take a sample |
| inData | input | 16 | Input sample, signed Q2.14 |
| twoSection | input | 1 | 1 selects two cascaded sections, 0 selects one |
| outValid | output | 1 | One-cycle pulse marking a new result |
| outData | output | 16 | Filter result, signed Q2.14 |
| coefWe | input | 1 | Coefficient write strobe |
| coefAddr | input | 4 | Coefficient address |
| coefData | input | 16 | Coefficient value, signed Q2.14 |

## Verification
The latency properties assume that `twoSection` is valid in the same cycle that `inValid` meets `inReady`. They also assume that reset is not raised partway through a window, which the disable clause covers. The index-end property assumes that a run is never cut short. The stimulus changes inputs only on falling clock edges, holds `inValid` high for exactly one accepting edge, sets the mode together with the sample, and writes coefficients only while the engine is idle. Expected results come from an untimed model of the section chain, and the coefficients are chosen so that wrap-around, flooring, pure delays and feedback decay each show up as hand-checkable values.

// File: rtl/biquad_pkg.sv
package biquad_pkg;
  parameter int DATA_W  = 16;               // sample and coefficient width
  parameter int FRAC_W  = 14;               // fraction bits (one = 1 << FRAC_W)
  parameter int ACC_W   = 32;               // accumulator width
  parameter int MAX_SEC = 2;                // sections available
  parameter int TAPS    = 5;                // coefficients per section
  parameter int NCOEF   = TAPS * MAX_SEC;
  parameter int NSTATE  = 2 * MAX_SEC + 2;
  parameter int CIDX_W  = $clog2(NCOEF + 1);
  parameter int SIDX_W  = $clog2(NSTATE + 1);
  parameter int SEC_W   = (MAX_SEC > 1) ? $clog2(MAX_SEC) : 1;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic              latchIn;   // capture inData as section input
    logic              accEn;     // update accumulator
    logic              accClear;  // start a new sum
    logic              useInput;  // multiply by section input, not history
    logic              shiftEn;   // push section input into history pair
    logic              loadIn;    // section result becomes next input
    logic [CIDX_W-1:0] coefIdx;
    logic [SIDX_W-1:0] dataIdx;
  } ctl_t;
endpackage

// File: rtl/biquad_ctrl.sv
module biquad_ctrl
  import biquad_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic inValid,
  input  logic twoSection,
  output logic inReady,
  output logic outValid,
  output ctl_t ctl
);
  typedef enum logic [3:0] {
    IDLE, TAP0, TAP1, TAP2, PUSH_IN, TAP3, TAP4, PUSH_OUT, EMIT
  } state_t;

  state_t            state, stateNext;
  logic [CIDX_W-1:0] coefPtr;
  logic [SIDX_W-1:0] dataPtr;
  logic [SEC_W-1:0]  secIdx;
  logic              twoLat;
  logic              accept;
  logic              lastSec;

  assign accept   = inValid && (state == IDLE);
  assign lastSec  = (secIdx == SEC_W'(twoLat));
  assign inReady  = (state == IDLE);
  assign outValid = (state == EMIT);

  always_comb begin
    ctl         = '0;
    ctl.coefIdx = coefPtr;
    ctl.dataIdx = dataPtr;
    ctl.latchIn = accept;
    stateNext   = state;
    case (state)
      IDLE:     if (accept) stateNext = TAP0;
      TAP0: begin
        ctl.accEn    = 1'b1;
        ctl.accClear = 1'b1;
        ctl.useInput = 1'b1;
        stateNext    = TAP1;
      end
      TAP1: begin ctl.accEn = 1'b1; stateNext = TAP2;    end
      TAP2: begin ctl.accEn = 1'b1; stateNext = PUSH_IN; end
      PUSH_IN: begin ctl.shiftEn = 1'b1; stateNext = TAP3; end
      TAP3: begin ctl.accEn = 1'b1; stateNext = TAP4;    end
      TAP4: begin
        ctl.accEn  = 1'b1;
        ctl.loadIn = 1'b1;
        stateNext  = lastSec ? PUSH_OUT : TAP0;
      end
      PUSH_OUT: begin ctl.shiftEn = 1'b1; stateNext = EMIT; end
      EMIT:     stateNext = IDLE;
      default:  stateNext = IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= IDLE;
      coefPtr <= '0;
      dataPtr <= '0;
      secIdx  <= '0;
      twoLat  <= 1'b0;
    end else begin
      state <= stateNext;
      case (state)
        IDLE: if (accept) begin
          coefPtr <= '0;
          dataPtr <= '0;
          secIdx  <= '0;
          twoLat  <= twoSection;
        end
        TAP0: coefPtr <= coefPtr + CIDX_W'(1);
        TAP1, TAP3: begin
          coefPtr <= coefPtr + CIDX_W'(1);
          dataPtr <= dataPtr + SIDX_W'(1);
        end
        TAP2: begin
          coefPtr <= coefPtr + CIDX_W'(1);
          dataPtr <= dataPtr - SIDX_W'(1);
        end
        TAP4: begin
          coefPtr <= coefPtr + CIDX_W'(1);
          dataPtr <= dataPtr - SIDX_W'(1);
          if (!lastSec) secIdx <= secIdx + SEC_W'(1);
        end
        PUSH_IN, PUSH_OUT: dataPtr <= dataPtr + SIDX_W'(2);
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/biquad_datapath.sv
module biquad_datapath
  import biquad_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  ctl_t              ctl,
  input  logic [DATA_W-1:0] inData,
  input  logic              coefWe,
  input  logic [CIDX_W-1:0] coefAddr,
  input  logic [DATA_W-1:0] coefData,
  output logic [DATA_W-1:0] outData
);
  logic [DATA_W-1:0] coefMem  [NCOEF];
  logic [DATA_W-1:0] stateMem [NSTATE];

  logic [DATA_W-1:0]          curIn, coefWord, stateWord;
  logic signed [DATA_W-1:0]   opA, opB;
  logic signed [2*DATA_W-1:0] product;
  logic signed [ACC_W-1:0]    scaled, acc, accNext;
  logic [SIDX_W-1:0]          pairIdx;

  assign coefWord  = (ctl.coefIdx < CIDX_W'(NCOEF)) ? coefMem[ctl.coefIdx] : '0;
  assign stateWord = (ctl.dataIdx < SIDX_W'(NSTATE)) ? stateMem[ctl.dataIdx] : '0;
  assign pairIdx   = ctl.dataIdx + SIDX_W'(1);

  // one shared multiplier, product scaled back to Q2.14 by flooring shift
  assign opA     = coefWord;
  assign opB     = ctl.useInput ? curIn : stateWord;
  assign product = opA * opB;
  assign scaled  = ACC_W'(product >>> FRAC_W);
  assign accNext = ctl.accClear ? scaled : acc + scaled;

  assign outData = curIn;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc   <= '0;
      curIn <= '0;
      for (int i = 0; i < NCOEF; i++)  coefMem[i]  <= '0;
      for (int i = 0; i < NSTATE; i++) stateMem[i] <= '0;
    end else begin
      if (ctl.accEn) acc <= accNext;
      if (ctl.latchIn)     curIn <= inData;
      else if (ctl.loadIn) curIn <= accNext[DATA_W-1:0];
      if (coefWe && (coefAddr < CIDX_W'(NCOEF))) coefMem[coefAddr] <= coefData;
      // history pair shift: newest takes the input, older takes old newest
      for (int i = 0; i < NSTATE; i++) begin
        if (ctl.shiftEn && (ctl.dataIdx == SIDX_W'(i)))  stateMem[i] <= curIn;
        else if (ctl.shiftEn && (pairIdx == SIDX_W'(i))) stateMem[i] <= stateWord;
      end
    end
  end
endmodule

// File: rtl/biquad_engine.sv
module biquad_engine
  import biquad_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  output logic              inReady,
  input  logic [DATA_W-1:0] inData,
  input  logic              twoSection,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  input  logic              coefWe,
  input  logic [CIDX_W-1:0] coefAddr,
  input  logic [DATA_W-1:0] coefData
);
  ctl_t ctl;

  biquad_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .inValid   (inValid),
    .twoSection(twoSection),
    .inReady   (inReady),
    .outValid  (outValid),
    .ctl       (ctl)
  );

  biquad_datapath u_dp (
    .clk     (clk),
    .rst     (rst),
    .ctl     (ctl),
    .inData  (inData),
    .coefWe  (coefWe),
    .coefAddr(coefAddr),
    .coefData(coefData),
    .outData (outData)
  );
endmodule

// File: rtl/biquad_engine_chk.sv
module biquad_engine_chk
  import biquad_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              inValid,
  input logic              inReady,
  input logic              twoSection,
  input logic              outValid,
  input logic              shiftEn,
  input logic [CIDX_W-1:0] coefIdx,
  input logic [SIDX_W-1:0] dataIdx
);
  logic accepted;
  assign accepted = inValid && inReady;

  // R7
  ready_drop_chk: assert property (@(posedge clk) disable iff (rst)
    accepted |=> !inReady);

  // R8
  latency_single_chk: assert property (@(posedge clk) disable iff (rst)
    (accepted && !twoSection) |-> ##8 outValid);

  // R8
  latency_dual_chk: assert property (@(posedge clk) disable iff (rst)
    (accepted && twoSection) |-> ##14 outValid);

  // R8
  pulse_once_chk: assert property (@(posedge clk) disable iff (rst)
    outValid |=> !outValid);

  // R4
  shift_even_chk: assert property (@(posedge clk) disable iff (rst)
    shiftEn |-> !dataIdx[0]);

  // R5
  index_end_chk: assert property (@(posedge clk) disable iff (rst)
    outValid |-> ((coefIdx == CIDX_W'(TAPS) && dataIdx == SIDX_W'(NSTATE - 2)) ||
                  (coefIdx == CIDX_W'(NCOEF) && dataIdx == SIDX_W'(NSTATE))));

  // R10
  reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (inReady && !outValid));
endmodule

bind biquad_engine biquad_engine_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .inValid   (inValid),
  .inReady   (inReady),
  .twoSection(twoSection),
  .outValid  (outValid),
  .shiftEn   (ctl.shiftEn),
  .coefIdx   (ctl.coefIdx),
  .dataIdx   (ctl.dataIdx)
);

// File: tb/biquad_engine_bench.sv
module biquad_engine_bench;
  import biquad_pkg::*;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              inValid = 1'b0;
  logic              inReady;
  logic [DATA_W-1:0] inData = '0;
  logic              twoSection = 1'b0;
  logic              outValid;
  logic [DATA_W-1:0] outData;
  logic              coefWe = 1'b0;
  logic [CIDX_W-1:0] coefAddr = '0;
  logic [DATA_W-1:0] coefData = '0;

  biquad_engine u_biquad_engine (
    .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady), .inData(inData),
    .twoSection(twoSection), .outValid(outValid), .outData(outData),
    .coefWe(coefWe), .coefAddr(coefAddr), .coefData(coefData)
  );

  always #4 clk = ~clk;  // 125 MHz

  int nChecks = 0;
  int nFail   = 0;
  logic [DATA_W-1:0] coefM [NCOEF];
  logic [DATA_W-1:0] stM   [NSTATE];
  logic [DATA_W-1:0] expQ [$];
  string             tagQ [$];
  logic [DATA_W-1:0] lastExp = '0;
  logic [15:0]       lfsr = 16'hACE1;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
  endtask

  function automatic logic signed [31:0] fmul(input logic [15:0] a, input logic [15:0] b);
    logic signed [31:0] p;
    p = $signed(a) * $signed(b);
    return p >>> 14;
  endfunction

  // untimed model of the section chain (R2..R6)
  function automatic logic [15:0] modelStep(input logic [15:0] xin, input bit two);
    logic signed [31:0] acc;
    logic [15:0] x;
    int nSec;
    x = xin;
    nSec = two ? 2 : 1;
    for (int s = 0; s < nSec; s++) begin
      acc = fmul(coefM[5*s], x);
      acc += fmul(coefM[5*s+1], stM[2*s]);
      acc += fmul(coefM[5*s+2], stM[2*s+1]);
      stM[2*s+1] = stM[2*s];
      stM[2*s]   = x;
      acc += fmul(coefM[5*s+3], stM[2*s+2]);
      acc += fmul(coefM[5*s+4], stM[2*s+3]);
      x = acc[15:0];
    end
    stM[2*nSec+1] = stM[2*nSec];
    stM[2*nSec]   = x;
    return x;
  endfunction

  // monitor: pop the scoreboard when a result appears
  always @(negedge clk) begin
    if (!rst && outValid) begin
      if (expQ.size() == 0) begin
        nChecks++;
        nFail++;
        $display("FAIL R8 unexpected output: actual=%0h expected=none", outData);
      end else begin
        check(tagQ.pop_front(), {16'h0, outData}, {16'h0, expQ.pop_front()});
      end
    end
  end

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; inValid = 1'b0; coefWe = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < NCOEF; i++)  coefM[i] = '0;
    for (int i = 0; i < NSTATE; i++) stM[i] = '0;
    expQ.delete();
    tagQ.delete();
  endtask

  task automatic writeCoef(input logic [CIDX_W-1:0] addr, input logic [15:0] val);
    @(negedge clk);
    coefWe = 1'b1; coefAddr = addr; coefData = val;
    if (int'(addr) < NCOEF) coefM[addr] = val;
    @(negedge clk);
    coefWe = 1'b0;
  endtask

  task automatic sendSample(input logic [15:0] x, input bit two, input string tag);
    int lat;
    @(negedge clk);
    while (!inReady) @(negedge clk);
    inValid = 1'b1; inData = x; twoSection = two;
    lastExp = modelStep(x, two);
    expQ.push_back(lastExp);
    tagQ.push_back(tag);
    @(negedge clk);
    inValid = 1'b0;
    lat = 1;
    check("R7 ready low while busy", {31'h0, inReady}, 32'h0);
    while (!outValid) begin
      @(negedge clk);
      lat++;
    end
    check("R8 latency", lat, two ? 14 : 8);
  endtask

  task automatic stepLfsr();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL R8 watchdog: actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < NCOEF; i++)  coefM[i] = '0;
    for (int i = 0; i < NSTATE; i++) stM[i] = '0;
    doReset();
    // R10 reset state at the ports
    check("R10 ready after reset", {31'h0, inReady}, 32'h1);
    check("R10 no pulse after reset", {31'h0, outValid}, 32'h0);
    check("R10 output cleared", {16'h0, outData}, 32'h0);

    // R2 pass-through with unity b0
    writeCoef(0, 16'h4000);
    sendSample(16'h1234, 1'b0, "R2 unity");
    sendSample(16'hC000, 1'b0, "R2 unity");
    sendSample(16'h7FFF, 1'b0, "R2 unity");

    // R1 flooring products
    writeCoef(0, 16'h2000);
    sendSample(16'hFFFF, 1'b0, "R1 floor model");
    check("R1 floor negative", {16'h0, outData}, 32'hFFFF);
    sendSample(16'h0003, 1'b0, "R1 floor model");
    check("R1 floor positive", {16'h0, outData}, 32'h0001);

    // R3 wrap without saturation
    doReset();
    writeCoef(0, 16'h4000);
    writeCoef(1, 16'h4000);
    sendSample(16'h7FFF, 1'b0, "R3 wrap model");
    sendSample(16'h7FFF, 1'b0, "R3 wrap model");
    check("R3 wrapped sum", {16'h0, outData}, 32'hFFFE);

    // R10 reset clears history; R4 delay taps
    doReset();
    writeCoef(1, 16'h4000);
    sendSample(16'h1234, 1'b0, "R10 cleared history");
    check("R10 history cleared", {16'h0, outData}, 32'h0);
    sendSample(16'h0000, 1'b0, "R4 delay one");
    check("R4 delay one tap", {16'h0, outData}, 32'h1234);
    writeCoef(1, 16'h0000);
    writeCoef(2, 16'h4000);
    sendSample(16'h0005, 1'b0, "R4 delay two");
    check("R4 delay two tap", {16'h0, outData}, 32'h1234);

    // R2 feedback: decaying impulse response
    doReset();
    writeCoef(0, 16'h4000);
    writeCoef(3, 16'h2000);
    sendSample(16'h4000, 1'b0, "R2 feedback");
    sendSample(16'h0000, 1'b0, "R2 feedback");
    sendSample(16'h0000, 1'b0, "R2 feedback");
    sendSample(16'h0000, 1'b0, "R2 feedback");
    check("R2 feedback decay", {16'h0, outData}, 32'h0800);
    writeCoef(4, 16'hF000);
    sendSample(16'h1000, 1'b0, "R2 signed feedback");
    sendSample(16'hE000, 1'b0, "R2 signed feedback");

    // R5 shared history between sections
    doReset();
    writeCoef(0, 16'h4000);
    writeCoef(5, 16'h4000);
    writeCoef(6, 16'h4000);
    sendSample(16'h0100, 1'b1, "R5 cascade");
    sendSample(16'h0200, 1'b1, "R5 cascade");
    check("R5 cascade shared history", {16'h0, outData}, 32'h0300);

    // R6 one-section mode ignores section-two coefficients
    sendSample(16'h0040, 1'b0, "R6 single");
    check("R6 single section only", {16'h0, outData}, 32'h0040);
    sendSample(16'h0080, 1'b1, "R6 back to dual");

    // mixed traffic in both modes
    writeCoef(0, 16'h1000); writeCoef(1, 16'h2000); writeCoef(2, 16'h1000);
    writeCoef(3, 16'h2CCD); writeCoef(4, 16'hE666);
    writeCoef(5, 16'h3000); writeCoef(6, 16'hD000); writeCoef(7, 16'h0800);
    writeCoef(8, 16'h1800); writeCoef(9, 16'hF000);
    for (int n = 0; n < 40; n++) begin
      stepLfsr();
      sendSample(lfsr, lfsr[0], "R5 R6 mixed");
    end

    // R9 writes beyond the coefficient range are dropped
    writeCoef(4'd12, 16'h7FFF);
    writeCoef(4'd15, 16'h4000);
    writeCoef(4'd10, 16'h2000);
    sendSample(16'h0321, 1'b1, "R9 out of range ignored");
    sendSample(16'hF00F, 1'b0, "R9 out of range ignored");

    // R8 result held after the pulse
    repeat (5) @(negedge clk);
    check("R8 output held", {16'h0, outData}, {16'h0, lastExp});
    check("R8 pulse ended", {31'h0, outValid}, 32'h0);
    check("R8 scoreboard drained", expQ.size(), 0);

    summary();
    $finish;
  end
endmodule